// File: doc/BRIEF.md
# Digit Crossfade Duty Scheduler

This block sits between the source of a four-digit display word and the serializer that shifts that word out to the display drivers. If the requested word equals the word already on the display, nothing happens and the stored word stays on the output. If the requested word differs, the block runs a crossfade. The output alternates between the new word and the old word, always starting with the new one. The new word's share of each phase pair grows by a fixed step, while the length of the pair stays constant.

Time is measured in ticks from an external millisecond tick generator. A duty value starts at `FADE_START`. Each time the new word is put on the output, the duty value grows by `FADE_STEP`, and the new word is held for that many ticks. The old word then fills the rest of the pair, `FADE_STOP - duty` ticks. The fade ends as soon as the duty value reaches or passes `FADE_STOP`. The new word then becomes the stored word.

The serializer reloads its frame on every `upd_o` strobe. While a fade runs, `busy_o` is high. A change of the request during a fade does not disturb that fade. The latest request is served once the fade is over. `FADE_STEP` must be at least 1.

Top module: `dfade_sched`

## Requirements
- R1: While `rst_ni` is low, `word_o` is 0, `upd_o` is 0 and `busy_o` is 0, and the stored word is 0.
- R2: When idle and `req_word_i` equals the stored word, `word_o` keeps that value, `upd_o` stays low and `busy_o` stays low.
- R3: When idle and `req_word_i` differs from the stored word, the next cycle shows `word_o` equal to that request, `upd_o` high for one cycle and `busy_o` high.
- R4: The k-th new-word phase of a fade (k = 1, 2, ...) lasts `FADE_START + k*FADE_STEP` ticks of `tick_ms_i`. Cycles without a tick do not advance any phase.
- R5: After a new-word phase whose duty value d is below `FADE_STOP`, the old word is shown for `FADE_STOP - d` ticks, and then the new word is shown again. Each pair therefore totals `FADE_STOP` ticks.
- R6: After a new-word phase whose duty value is at or above `FADE_STOP`, the old-word phase is skipped and the fade ends. `busy_o` falls, `word_o` keeps the new word with no strobe, and the new word becomes the stored word.
- R7: A request change during a fade does not alter the words or the timing of that fade. In the cycle after `busy_o` falls, the block compares the request present then and starts a new fade toward it if it differs.
- R8: `word_o` changes only in a cycle in which `upd_o` is high, and `upd_o` is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_word_i | input | NUM_DIG*DIG_W | Requested digit word (level) |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| word_o | output | NUM_DIG*DIG_W | Word currently selected for the display |
| upd_o | output | 1 | One-cycle strobe: `word_o` was just reloaded |
| busy_o | output | 1 | High while a crossfade runs |

## Verification
On every cycle, the assertions check four things. The output word changes only together with the update strobe. An idle request either starts a fade on the next cycle or leaves the block quiet. An idle output always equals the stored word. The duty value stays between its first and last legal values. Only the bench's scenarios can show the phase lengths and the hand-over of pending requests. For the lengths, the bench counts the ticks between strobes, with randomly spaced ticks, and compares them with the growing-duty schedule. For the hand-over, it changes the request in the middle of a fade: to a third word, back to the word being faded in, and back to the previous word.

// File: rtl/dfade_pkg.sv
package dfade_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEW  = 2'd1,
    ST_OLD  = 2'd2
  } fade_st_e;
endpackage

// File: rtl/dfade_cmp.sv
module dfade_cmp #(
  parameter int NUM_DIG = 4,
  parameter int DIG_W   = 4
) (
  input  logic [NUM_DIG*DIG_W-1:0] a_i,
  input  logic [NUM_DIG*DIG_W-1:0] b_i,
  output logic                     diff_o
);
  logic [NUM_DIG-1:0] dig_ne;

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    assign dig_ne[g] = |(a_i[g*DIG_W +: DIG_W] ^ b_i[g*DIG_W +: DIG_W]);
  end

  assign diff_o = |dig_ne;
endmodule

// File: rtl/dfade_timer.sv
module dfade_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (run_i && tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dfade_duty.sv
module dfade_duty #(
  parameter int CNT_W      = 5,
  parameter int FADE_START = 0,
  parameter int FADE_STEP  = 1,
  parameter int FADE_STOP  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic [CNT_W-1:0] rest_o,
  output logic             final_o
);
  localparam logic [CNT_W-1:0] START_C = CNT_W'(FADE_START);
  localparam logic [CNT_W-1:0] STEP_C  = CNT_W'(FADE_STEP);
  localparam logic [CNT_W-1:0] STOP_C  = CNT_W'(FADE_STOP);

  logic [CNT_W-1:0] duty_q;

  assign nxt_o   = (init_i ? START_C : duty_q) + STEP_C;
  assign final_o = (duty_q >= STOP_C);
  assign rest_o  = final_o ? '0 : (STOP_C - duty_q);
  assign duty_o  = duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= START_C;
    end else if (init_i || adv_i) begin
      duty_q <= nxt_o;
    end
  end
endmodule

// File: rtl/dfade_sched.sv
module dfade_sched
  import dfade_pkg::*;
#(
  parameter int NUM_DIG    = 4,
  parameter int DIG_W      = 4,
  parameter int FADE_START = 0,
  parameter int FADE_STEP  = 1,
  parameter int FADE_STOP  = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_DIG*DIG_W-1:0] req_word_i,
  input  logic                     tick_ms_i,
  output logic [NUM_DIG*DIG_W-1:0] word_o,
  output logic                     upd_o,
  output logic                     busy_o
);
  localparam int WORD_W = NUM_DIG * DIG_W;
  localparam int CNT_W  = $clog2(FADE_STOP + FADE_STEP + 1);

  fade_st_e          st_q, st_d;
  logic [WORD_W-1:0] old_q, new_q, word_q;
  logic              upd_q;

  logic              req_diff, tmr_exp, duty_final;
  logic [CNT_W-1:0]  duty_val, nxt_len, old_len, tmr_len;
  logic              start, new_end, old_end, to_old, fin, tmr_load, tmr_run;

  dfade_cmp #(.NUM_DIG(NUM_DIG), .DIG_W(DIG_W)) u_cmp (
    .a_i   (req_word_i),
    .b_i   (old_q),
    .diff_o(req_diff)
  );

  dfade_duty #(
    .CNT_W(CNT_W), .FADE_START(FADE_START), .FADE_STEP(FADE_STEP), .FADE_STOP(FADE_STOP)
  ) u_duty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (start),
    .adv_i  (old_end),
    .duty_o (duty_val),
    .nxt_o  (nxt_len),
    .rest_o (old_len),
    .final_o(duty_final)
  );

  dfade_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .len_i   (tmr_len),
    .run_i   (tmr_run),
    .tick_i  (tick_ms_i),
    .expire_o(tmr_exp)
  );

  assign start    = (st_q == ST_IDLE) && req_diff;
  assign new_end  = (st_q == ST_NEW) && tmr_exp;
  assign old_end  = (st_q == ST_OLD) && tmr_exp;
  assign fin      = new_end && duty_final;
  // old phase is skipped when its length would be zero or negative
  assign to_old   = new_end && !duty_final;
  assign tmr_load = start || to_old || old_end;
  assign tmr_len  = to_old ? old_len : nxt_len;
  assign tmr_run  = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)   st_d = ST_NEW;
      ST_NEW:  if (fin)     st_d = ST_IDLE;
               else if (to_old) st_d = ST_OLD;
      ST_OLD:  if (old_end) st_d = ST_NEW;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      old_q  <= '0;
      new_q  <= '0;
      word_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      upd_q <= start || to_old || old_end;
      if (start) begin
        new_q  <= req_word_i;
        word_q <= req_word_i;
      end else if (to_old) begin
        word_q <= old_q;
      end else if (old_end) begin
        word_q <= new_q;
      end
      if (fin) old_q <= new_q;
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;
  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/dfade_sched_chk.sv
module dfade_sched_chk #(
  parameter int NUM_DIG    = 4,
  parameter int DIG_W      = 4,
  parameter int FADE_START = 0,
  parameter int FADE_STEP  = 1,
  parameter int FADE_STOP  = 20
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_DIG*DIG_W-1:0] req_word_i,
  input logic [NUM_DIG*DIG_W-1:0] word_o,
  input logic                     upd_o,
  input logic                     busy_o,
  input logic [NUM_DIG*DIG_W-1:0] stored_i,
  input logic [$clog2(FADE_STOP+FADE_STEP+1)-1:0] duty_i
);
  localparam int CNT_W = $clog2(FADE_STOP + FADE_STEP + 1);
  localparam logic [CNT_W-1:0] DUTY_LO = CNT_W'(FADE_START + FADE_STEP);
  localparam logic [CNT_W-1:0] DUTY_HI = CNT_W'(FADE_STOP + FADE_STEP - 1);

  // R8
  word_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> upd_o);

  // R8
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> busy_o);

  // R3
  fade_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (req_word_i != word_o)) |=> (busy_o && upd_o && (word_o == $past(req_word_i))));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (req_word_i == word_o)) |=> (!busy_o && !upd_o));

  // R6
  idle_stored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (word_o == stored_i));

  // R6
  fade_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (!upd_o && $stable(word_o)));

  // R4
  duty_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ((duty_i >= DUTY_LO) && (duty_i <= DUTY_HI)));
endmodule

bind dfade_sched dfade_sched_chk #(
  .NUM_DIG(NUM_DIG), .DIG_W(DIG_W),
  .FADE_START(FADE_START), .FADE_STEP(FADE_STEP), .FADE_STOP(FADE_STOP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_word_i(req_word_i),
  .word_o    (word_o),
  .upd_o     (upd_o),
  .busy_o    (busy_o),
  .stored_i  (old_q),
  .duty_i    (duty_val)
);

// File: tb/dfade_sched_bench.sv
module dfade_sched_bench;
  localparam int F_START = 0;
  localparam int F_STEP  = 1;
  localparam int F_STOP  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] req = '0;
  logic [15:0] word;
  logic        upd, busy;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  dfade_sched #(
    .NUM_DIG(4), .DIG_W(4),
    .FADE_START(F_START), .FADE_STEP(F_STEP), .FADE_STOP(F_STOP)
  ) u_dfade_sched (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_word_i(req),
    .tick_ms_i (tick),
    .word_o    (word),
    .upd_o     (upd),
    .busy_o    (busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive the tick for the next edge, then move to the following falling edge
  task automatic next_cycle();
    tick = ($urandom_range(0, 2) == 0);
    tick_cnt += int'(tick);
    @(negedge clk);
  endtask

  task automatic wait_evt();
    int guard = 0;
    do begin
      next_cycle();
      guard++;
    end while (!(upd || !busy) && guard < 5000);
  endtask

  // caller has already placed the target word on req
  task automatic run_fade(input logic [15:0] w, input logic [15:0] prev,
                          input bit disturb, input logic [15:0] dw);
    int duty = F_START;
    next_cycle();
    // R3: new word first, strobe, busy
    chk(upd && busy && word == w, "R3 start", {upd, busy, word}, {2'b11, w});
    if (disturb) req = dw;
    forever begin
      duty += F_STEP;
      tick_cnt = 0;
      wait_evt();
      // R4: new phase length
      chk(tick_cnt == duty, "R4 new phase ticks", tick_cnt, duty);
      if (duty >= F_STOP) begin
        // R6: old phase skipped, fade ends with no strobe
        chk(!busy && !upd && word == w, "R6 end", {upd, busy, word}, {2'b00, w});
        break;
      end
      // R5 / R7: old word shown, unaffected by a pending request
      chk(upd && busy && word == prev, "R5 old word", word, prev);
      tick_cnt = 0;
      wait_evt();
      chk(tick_cnt == F_STOP - duty, "R5 old phase ticks", tick_cnt, F_STOP - duty);
      chk(upd && busy && word == w, "R7 new word again", word, w);
    end
  endtask

  task automatic expect_quiet(input logic [15:0] w, input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      next_cycle();
      if (upd || busy || word != w) ok = 1'b0;
    end
    chk(ok, tag, {upd, busy, word}, {2'b00, w});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] cur, w, dw;
    void'($urandom(32'h1c3f_07a5));
    repeat (3) @(negedge clk);
    // R1
    chk(word == 16'h0 && !upd && !busy, "R1 reset", {upd, busy, word}, 18'h0);
    rst_n = 1'b1;
    cur = 16'h0;

    // R2: equal request, nothing happens
    req = 16'h0000;
    expect_quiet(cur, 12, "R2 equal request idle");

    // plain fade
    req = 16'h1234;
    run_fade(16'h1234, cur, 1'b0, 16'h0);
    cur = 16'h1234;
    // R6: new word is now stored
    expect_quiet(cur, 8, "R6 stored after fade");

    // R7: pending third word is served right after the fade
    req = 16'h5678;
    run_fade(16'h5678, cur, 1'b1, 16'h9abc);
    cur = 16'h5678;
    run_fade(16'h9abc, cur, 1'b0, 16'h0);
    cur = 16'h9abc;

    // R7: request returns to the word being faded in, no follow-up fade
    req = 16'hf0f0;
    run_fade(16'hf0f0, cur, 1'b1, 16'hf0f0);
    cur = 16'hf0f0;
    expect_quiet(cur, 8, "R7 pending equals new word");

    // R7: request returns to previous word, fades back
    req = 16'h0f0f;
    run_fade(16'h0f0f, cur, 1'b1, cur);
    run_fade(cur, 16'h0f0f, 1'b0, 16'h0);

    // random words with random disturbance
    for (int k = 0; k < 4; k++) begin
      do w = 16'($urandom_range(0, 65535)); while (w == cur);
      req = w;
      if ($urandom_range(0, 1) == 1) begin
        do dw = 16'($urandom_range(0, 65535)); while (dw == w);
        run_fade(w, cur, 1'b1, dw);
        run_fade(dw, w, 1'b0, 16'h0);
        cur = dw;
      end else begin
        run_fade(w, cur, 1'b0, 16'h0);
        cur = w;
      end
      expect_quiet(cur, 4, "R2 quiet after random fade");
    end

    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule